// File: doc/BRIEF.md
# Static Memory Bank Bus Controller

This controller runs an asynchronous external static-memory bus on behalf of an internal requester. The bus is shared by four banks, and each bank has its own active-low chip select. A request carries a bank number, a byte offset, a read/write flag and write data. The controller then plays out a timed pin sequence and, for reads, returns the sampled data with a one-cycle valid pulse.

Every bank holds its own timing set, in clock cycles, for six intervals. The address lead before chip select and the address tail after it come first and last. Next come the chip-select lead and lag around the strobe. The strobe (access) length is held in a 5-bit field and always lasts at least one cycle. The last interval is the length of each extra page beat. A bank also selects a 1- or 2-byte data width and either single or four-item page reads. A configuration strobe with a bank index loads all of one bank's fields in one cycle.

An accepted request takes a snapshot of its bank's settings. A configuration write that arrives while an access is running therefore only affects later accesses.

Top module: `stmem_bus_ctrl`

## Requirements
- R1: While reset is high and while idle, every chip select, the output enable and the write enable are high (inactive), the data driver enable is low, `mem_addr` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: During an access only the chip select of the requested bank goes low (bit n of `mem_cs_n` belongs to bank n), and no two chip selects are ever low together.
- R3: After a request is accepted, a read plays out these intervals in order: address set-up (asu cycles, chip selects high, address driven), chip-select set-up (cssu cycles, selected chip select low, strobes high), access (acc+1 cycles, output enable low), chip-select hold (cshold cycles, chip select low, strobes high), address hold (ahold cycles, chip selects high, address still driven). An interval whose count is zero is skipped.
- R4: The access count is 5 bits wide, so the access interval lasts from 1 cycle (count 0) up to 32 cycles (count 31).
- R5: A write uses the same interval sequence, with write enable low in place of output enable. `mem_dq_oe` is high and `mem_dq_out` carries the write data only during the access interval. Page mode never applies to writes.
- R6: On a read, `mem_dq_in` is sampled on the last cycle of the access interval and of each page beat. In the next cycle `rsp_valid` is high for one cycle, with the sampled value on `rsp_rdata`.
- R7: On a 1-byte bank, reads return {8'h00, mem_dq_in[7:0]} and writes drive {8'h00, wdata[7:0]}. On a 2-byte bank all 16 bits pass through.
- R8: A read on a bank in four-item page mode adds three page beats after the access interval. Each beat lasts the page count, or 1 cycle when that count is 0. Chip select and output enable stay low across the beats, and the address steps by the bank width in bytes on each beat. Every beat produces its own `rsp_valid` pulse.
- R9: `req_ready` is low from the first cycle after acceptance through the last address-hold cycle. A request is accepted only on a clock edge where `req_valid` and `req_ready` are both high.
- R10: A cycle with `cfg_we` high loads all fields of bank `cfg_bank`. After reset every bank has zero timing counts, 1-byte width and single-item mode. A configuration write during an access leaves that access unchanged.
- R11: From acceptance to the end of address hold, `mem_addr` equals the request offset plus beat × width. Outside page beats the address does not change while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load one bank's settings |
| cfg_bank | input | 2 | Bank being configured |
| cfg_t_page | input | 4 | Page beat length |
| cfg_t_ahold | input | 4 | Address hold after chip select |
| cfg_t_cshold | input | 4 | Chip-select hold after strobe |
| cfg_t_acc | input | 5 | Access length minus one |
| cfg_t_cssu | input | 4 | Chip-select set-up before strobe |
| cfg_t_asu | input | 4 | Address set-up before chip select |
| cfg_wide | input | 1 | 1 = 2-byte bank, 0 = 1-byte bank |
| cfg_page4 | input | 1 | 1 = four-item page reads |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_bank | input | 2 | Target bank |
| req_offset | input | ADDR_W | Byte offset |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 16 | Data driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
The checker assumes that a request is presented only through the handshake, so the bank and offset of an access come from the accepted request alone. It also assumes that the memory side drives `mem_dq_in` as a pure function of the address. The bench holds `req_valid` high for exactly one edge, and only while `req_ready` is high. It models the memory as a combinational function of `mem_addr`. Configuration writes happen only from idle, except in the one deliberate case where a bank is reprogrammed during its own access to show that the snapshot isolates the running access.

// File: rtl/stmem_pkg.sv
package stmem_pkg;

    localparam int NBANK      = 4;
    localparam int BANK_W     = $clog2(NBANK);
    localparam int TIM_W      = 4;
    localparam int ACC_W      = 5;
    localparam int LEN_W      = ACC_W + 1;
    localparam int BYTE_W     = 8;
    localparam int DATA_W     = 2 * BYTE_W;
    localparam int PAGE_BEATS = 4;
    localparam int BEAT_W     = $clog2(PAGE_BEATS);
    localparam int NPHASE     = 6;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ASU  = 3'd1,
        PH_CSU  = 3'd2,
        PH_ACC  = 3'd3,
        PH_PAGE = 3'd4,
        PH_CSH  = 3'd5,
        PH_AH   = 3'd6
    } phase_e;

    typedef struct packed {
        logic [TIM_W-1:0] t_page;
        logic [TIM_W-1:0] t_ahold;
        logic [TIM_W-1:0] t_cshold;
        logic [ACC_W-1:0] t_acc;
        logic [TIM_W-1:0] t_cssu;
        logic [TIM_W-1:0] t_asu;
        logic             wide;
        logic             page4;
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '0;

    // successor in the fixed interval order
    function automatic phase_e phase_after(input phase_e p);
        case (p)
            PH_ASU:  return PH_CSU;
            PH_CSU:  return PH_ACC;
            PH_ACC:  return PH_PAGE;
            PH_PAGE: return PH_CSH;
            PH_CSH:  return PH_AH;
            default: return PH_IDLE;
        endcase
    endfunction

    // length in cycles of an interval for a given bank setting
    function automatic logic [LEN_W-1:0] phase_len(input phase_e p,
                                                   input bank_cfg_t c,
                                                   input logic wr);
        case (p)
            PH_ASU:  return LEN_W'(c.t_asu);
            PH_CSU:  return LEN_W'(c.t_cssu);
            PH_ACC:  return LEN_W'(c.t_acc) + LEN_W'(1);
            PH_PAGE: return (c.page4 && !wr)
                            ? ((c.t_page == '0) ? LEN_W'(1) : LEN_W'(c.t_page))
                            : '0;
            PH_CSH:  return LEN_W'(c.t_cshold);
            PH_AH:   return LEN_W'(c.t_ahold);
            default: return '0;
        endcase
    endfunction

    // first interval at or after p that actually lasts a cycle
    function automatic phase_e first_live(input phase_e p,
                                          input bank_cfg_t c,
                                          input logic wr);
        phase_e q;
        q = p;
        for (int i = 0; i < NPHASE; i++) begin
            if (q != PH_IDLE && phase_len(q, c, wr) == '0)
                q = phase_after(q);
        end
        return q;
    endfunction

    function automatic logic [ACC_W-1:0] load_count(input phase_e p,
                                                    input bank_cfg_t c,
                                                    input logic wr);
        logic [LEN_W-1:0] n;
        n = phase_len(p, c, wr);
        return (n == '0) ? '0 : ACC_W'(n - LEN_W'(1));
    endfunction

endpackage

// File: rtl/stmem_cfg_regs.sv
module stmem_cfg_regs
    import stmem_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [BANK_W-1:0]           wr_bank,
    input  bank_cfg_t                   wr_data,
    output bank_cfg_t [NBANK-1:0]       bank_q
);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                bank_q[b] <= CFG_RESET;
            else if (wr_en && wr_bank == BANK_W'(b))
                bank_q[b] <= wr_data;
        end
    end

endmodule

// File: rtl/stmem_seq.sv
module stmem_seq
    import stmem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  bank_cfg_t           start_cfg,
    input  logic [BANK_W-1:0]   start_bank,
    input  logic [ADDR_W-1:0]   start_off,
    input  logic                start_wr,
    input  logic [DATA_W-1:0]   start_wdata,
    output phase_e              ph_q,
    output logic [BEAT_W-1:0]   beat_q,
    output logic                cnt_last,
    output bank_cfg_t           act_cfg,
    output logic [BANK_W-1:0]   act_bank,
    output logic [ADDR_W-1:0]   act_off,
    output logic                act_wr,
    output logic [DATA_W-1:0]   act_wdata
);

    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(PAGE_BEATS - 1);

    logic [ACC_W-1:0] cnt_q;
    phase_e           launch_ph;
    phase_e           follow_ph;
    logic             page_again;

    always_comb begin
        launch_ph  = first_live(PH_ASU, start_cfg, start_wr);
        follow_ph  = first_live(phase_after(ph_q), act_cfg, act_wr);
        page_again = (ph_q == PH_PAGE) && (beat_q != BEAT_LAST);
        cnt_last   = (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            cnt_q     <= '0;
            beat_q    <= '0;
            act_cfg   <= CFG_RESET;
            act_bank  <= '0;
            act_off   <= '0;
            act_wr    <= 1'b0;
            act_wdata <= '0;
        end else if (ph_q == PH_IDLE) begin
            if (start) begin
                act_cfg   <= start_cfg;
                act_bank  <= start_bank;
                act_off   <= start_off;
                act_wr    <= start_wr;
                act_wdata <= start_wdata;
                ph_q      <= launch_ph;
                cnt_q     <= load_count(launch_ph, start_cfg, start_wr);
                beat_q    <= '0;
            end
        end else if (!cnt_last) begin
            cnt_q <= cnt_q - ACC_W'(1);
        end else if (page_again) begin
            beat_q <= beat_q + BEAT_W'(1);
            cnt_q  <= load_count(PH_PAGE, act_cfg, act_wr);
        end else begin
            ph_q  <= follow_ph;
            cnt_q <= load_count(follow_ph, act_cfg, act_wr);
            if (follow_ph == PH_PAGE)
                beat_q <= beat_q + BEAT_W'(1);
        end
    end

endmodule

// File: rtl/stmem_pins.sv
module stmem_pins
    import stmem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_e              ph,
    input  logic [BEAT_W-1:0]   beat,
    input  logic                cnt_last,
    input  bank_cfg_t           cfg,
    input  logic [BANK_W-1:0]   bank,
    input  logic [ADDR_W-1:0]   off,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   dq_in,
    output logic [ADDR_W-1:0]   addr,
    output logic [NBANK-1:0]    cs_n,
    output logic                oe_n,
    output logic                we_n,
    output logic [DATA_W-1:0]   dq_out,
    output logic                dq_oe,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata
);

    logic bus_on;
    logic strobe;
    logic capture;
    logic [DATA_W-1:0] wdata_fit;
    logic [DATA_W-1:0] rdata_fit;

    always_comb begin
        bus_on  = (ph == PH_CSU) || (ph == PH_ACC) || (ph == PH_PAGE) || (ph == PH_CSH);
        strobe  = (ph == PH_ACC) || (ph == PH_PAGE);
        capture = strobe && !wr && cnt_last;

        wdata_fit = cfg.wide ? wdata : {{(DATA_W-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
        rdata_fit = cfg.wide ? dq_in : {{(DATA_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]};

        for (int b = 0; b < NBANK; b++)
            cs_n[b] = !(bus_on && bank == BANK_W'(b));

        oe_n   = !(strobe && !wr);
        we_n   = !((ph == PH_ACC) && wr);
        dq_oe  = (ph == PH_ACC) && wr;
        dq_out = dq_oe ? wdata_fit : '0;
        addr   = (ph == PH_IDLE) ? '0
                                 : off + (ADDR_W'(beat) << cfg.wide);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= rdata_fit;
        end
    end

endmodule

// File: rtl/stmem_bus_ctrl.sv
module stmem_bus_ctrl
    import stmem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [BANK_W-1:0]    cfg_bank,
    input  logic [TIM_W-1:0]     cfg_t_page,
    input  logic [TIM_W-1:0]     cfg_t_ahold,
    input  logic [TIM_W-1:0]     cfg_t_cshold,
    input  logic [ACC_W-1:0]     cfg_t_acc,
    input  logic [TIM_W-1:0]     cfg_t_cssu,
    input  logic [TIM_W-1:0]     cfg_t_asu,
    input  logic                 cfg_wide,
    input  logic                 cfg_page4,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ADDR_W-1:0]    req_offset,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [NBANK-1:0]     mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W-1:0]    mem_dq_out,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_in
);

    bank_cfg_t              cfg_word;
    bank_cfg_t [NBANK-1:0]  bank_cfg;
    phase_e                 ph;
    logic [BEAT_W-1:0]      beat;
    logic                   cnt_last;
    bank_cfg_t              act_cfg;
    logic [BANK_W-1:0]      act_bank;
    logic [ADDR_W-1:0]      act_off;
    logic                   act_wr;
    logic [DATA_W-1:0]      act_wdata;
    logic                   start;

    always_comb begin
        cfg_word.t_page   = cfg_t_page;
        cfg_word.t_ahold  = cfg_t_ahold;
        cfg_word.t_cshold = cfg_t_cshold;
        cfg_word.t_acc    = cfg_t_acc;
        cfg_word.t_cssu   = cfg_t_cssu;
        cfg_word.t_asu    = cfg_t_asu;
        cfg_word.wide     = cfg_wide;
        cfg_word.page4    = cfg_page4;
        req_ready         = (ph == PH_IDLE);
        start             = req_valid && req_ready;
    end

    stmem_cfg_regs u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_bank (cfg_bank),
        .wr_data (cfg_word),
        .bank_q  (bank_cfg)
    );

    stmem_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_cfg   (bank_cfg[req_bank]),
        .start_bank  (req_bank),
        .start_off   (req_offset),
        .start_wr    (req_write),
        .start_wdata (req_wdata),
        .ph_q        (ph),
        .beat_q      (beat),
        .cnt_last    (cnt_last),
        .act_cfg     (act_cfg),
        .act_bank    (act_bank),
        .act_off     (act_off),
        .act_wr      (act_wr),
        .act_wdata   (act_wdata)
    );

    stmem_pins #(.ADDR_W(ADDR_W)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .ph        (ph),
        .beat      (beat),
        .cnt_last  (cnt_last),
        .cfg       (act_cfg),
        .bank      (act_bank),
        .off       (act_off),
        .wr        (act_wr),
        .wdata     (act_wdata),
        .dq_in     (mem_dq_in),
        .addr      (mem_addr),
        .cs_n      (mem_cs_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_out    (mem_dq_out),
        .dq_oe     (mem_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: rtl/stmem_bus_ctrl_chk.sv
module stmem_bus_ctrl_chk
    import stmem_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NBANK-1:0]  mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);

    logic cs_any;
    assign cs_any = (mem_cs_n != '1);

    assert_cs_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    assert_oe_under_cs_R3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> cs_any);

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));

    assert_dq_with_we_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && cs_any));

    assert_rsp_follows_oe_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!mem_oe_n));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        cs_any |-> !req_ready);

    assert_addr_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (cs_any && $past(cs_any) && mem_oe_n && $past(mem_oe_n)) |-> $stable(mem_addr));

endmodule

bind stmem_bus_ctrl stmem_bus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/stmem_bus_ctrl_test.sv
module stmem_bus_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [3:0]  cfg_t_page = '0, cfg_t_ahold = '0, cfg_t_cshold = '0;
    logic [4:0]  cfg_t_acc = '0;
    logic [3:0]  cfg_t_cssu = '0, cfg_t_asu = '0;
    logic        cfg_wide = 1'b0, cfg_page4 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [AW-1:0] req_offset = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, mem_dq_oe;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench copy of each bank's settings, kept from what it writes
    int m_page[4], m_ah[4], m_csh[4], m_acc[4], m_css[4], m_as[4];
    bit m_wide[4], m_p4[4];

    function automatic logic [15:0] mem_word(input logic [AW-1:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h31};
    endfunction

    assign mem_dq_in = mem_word(mem_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    stmem_bus_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_t_page(cfg_t_page), .cfg_t_ahold(cfg_t_ahold), .cfg_t_cshold(cfg_t_cshold),
        .cfg_t_acc(cfg_t_acc), .cfg_t_cssu(cfg_t_cssu), .cfg_t_asu(cfg_t_asu),
        .cfg_wide(cfg_wide), .cfg_page4(cfg_page4),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_offset(req_offset), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check_eq(input string tag, input string fld, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, fld, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int b, input int pg, input int ah, input int csh,
                           input int acc, input int css, input int as_n,
                           input bit wide, input bit p4);
        cfg_bank = 2'(b); cfg_t_page = 4'(pg); cfg_t_ahold = 4'(ah);
        cfg_t_cshold = 4'(csh); cfg_t_acc = 5'(acc); cfg_t_cssu = 4'(css);
        cfg_t_asu = 4'(as_n); cfg_wide = wide; cfg_page4 = p4; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        m_page[b] = pg; m_ah[b] = ah; m_csh[b] = csh; m_acc[b] = acc;
        m_css[b] = css; m_as[b] = as_n; m_wide[b] = wide; m_p4[b] = p4;
    endtask

    // phase codes: 0 idle, 1 addr setup, 2 cs setup, 3 access, 4 page beat, 5 cs hold, 6 addr hold
    task automatic run_access(input int b, input int off, input bit wr,
                              input logic [15:0] wd, input string tag,
                              input bit mid, input int mid_acc);
        int q_ph[$];
        int q_beat[$];
        bit q_cap[$];
        int bytes;
        int bt;
        bytes = m_wide[b] ? 2 : 1;
        bt = 0;
        for (int k = 0; k < m_as[b]; k++) begin q_ph.push_back(1); q_beat.push_back(0); q_cap.push_back(0); end
        for (int k = 0; k < m_css[b]; k++) begin q_ph.push_back(2); q_beat.push_back(0); q_cap.push_back(0); end
        for (int k = 0; k <= m_acc[b]; k++) begin
            q_ph.push_back(3); q_beat.push_back(0); q_cap.push_back(!wr && k == m_acc[b]);
        end
        if (!wr && m_p4[b]) begin
            for (int beat = 1; beat < 4; beat++) begin
                int n;
                n = (m_page[b] == 0) ? 1 : m_page[b];
                for (int k = 0; k < n; k++) begin
                    q_ph.push_back(4); q_beat.push_back(beat); q_cap.push_back(k == n - 1);
                end
            end
            bt = 3;
        end
        for (int k = 0; k < m_csh[b]; k++) begin q_ph.push_back(5); q_beat.push_back(bt); q_cap.push_back(0); end
        for (int k = 0; k < m_ah[b]; k++) begin q_ph.push_back(6); q_beat.push_back(bt); q_cap.push_back(0); end
        q_ph.push_back(0); q_beat.push_back(0); q_cap.push_back(0);

        check_eq(tag, "ready before request R9", int'(req_ready), 1);
        req_bank = 2'(b); req_offset = AW'(off); req_write = wr; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;

        for (int i = 0; i < q_ph.size(); i++) begin
            int ph;
            int e_cs, e_addr;
            bit e_oe_n, e_we_n, e_dq_oe, e_rv;
            ph = q_ph[i];
            e_cs = (ph >= 2 && ph <= 5) ? (4'hF & ~(4'h1 << b)) : 4'hF;
            e_oe_n = !(!wr && (ph == 3 || ph == 4));
            e_we_n = !(wr && ph == 3);
            e_dq_oe = wr && ph == 3;
            e_addr = (ph == 0) ? 0 : ((off + q_beat[i] * bytes) & 16'hFFFF);
            e_rv = (i > 0) && q_cap[i-1];
            check_eq(tag, "cs_n R2", int'(mem_cs_n), e_cs);
            check_eq(tag, (ph == 4) ? "oe_n R8" : "oe_n R3", int'(mem_oe_n), int'(e_oe_n));
            check_eq(tag, "we_n R5", int'(mem_we_n), int'(e_we_n));
            check_eq(tag, "dq_oe R5", int'(mem_dq_oe), int'(e_dq_oe));
            check_eq(tag, "addr R11", int'(mem_addr), e_addr);
            check_eq(tag, "ready R9", int'(req_ready), int'(ph == 0));
            check_eq(tag, "rsp_valid R6", int'(rsp_valid), int'(e_rv));
            if (e_dq_oe)
                check_eq(tag, "dq_out R7", int'(mem_dq_out),
                         m_wide[b] ? int'(wd) : int'(wd[7:0]));
            if (e_rv) begin
                logic [15:0] w;
                w = mem_word(AW'(off + q_beat[i-1] * bytes));
                check_eq(tag, "rsp_rdata R7", int'(rsp_rdata),
                         m_wide[b] ? int'(w) : int'(w[7:0]));
            end
            if (mid && i == 2) begin
                cfg_bank = 2'(b); cfg_t_page = 4'(m_page[b]); cfg_t_ahold = 4'(m_ah[b]);
                cfg_t_cshold = 4'(m_csh[b]); cfg_t_acc = 5'(mid_acc); cfg_t_cssu = 4'(m_css[b]);
                cfg_t_asu = 4'(m_as[b]); cfg_wide = m_wide[b]; cfg_page4 = m_p4[b];
                cfg_we = 1'b1;
            end
            if (mid && i == 3) cfg_we = 1'b0;
            if (i < q_ph.size() - 1) @(negedge clk);
        end
        if (mid) m_acc[b] = mid_acc;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int b = 0; b < 4; b++) begin
            m_page[b] = 0; m_ah[b] = 0; m_csh[b] = 0; m_acc[b] = 0;
            m_css[b] = 0; m_as[b] = 0; m_wide[b] = 0; m_p4[b] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pins in reset
        check_eq("R1", "cs_n in reset", int'(mem_cs_n), 4'hF);
        check_eq("R1", "oe_n in reset", int'(mem_oe_n), 1);
        check_eq("R1", "we_n in reset", int'(mem_we_n), 1);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check_eq("R1", "cs_n idle", int'(mem_cs_n), 4'hF);
        check_eq("R1", "dq_oe idle", int'(mem_dq_oe), 0);
        check_eq("R1", "addr idle", int'(mem_addr), 0);
        check_eq("R1", "rsp_valid idle", int'(rsp_valid), 0);
        check_eq("R1", "ready idle", int'(req_ready), 1);

        // R10 defaults: zero timing, 1-byte, single item; R4 access count 0 gives one cycle
        run_access(0, 16'h0123, 1'b0, 16'h0, "R10_default_R4", 0, 0);

        // R3 full read sequence on a 1-byte bank, R2 bank select
        set_cfg(1, 0, 1, 2, 3, 1, 2, 1'b0, 1'b0);
        run_access(1, 16'h0040, 1'b0, 16'h0, "R3_read_R2", 0, 0);
        // R5 write, R7 upper byte cleared on 1-byte bank
        run_access(1, 16'h0041, 1'b1, 16'hBEEF, "R5_write_R7", 0, 0);

        // R4 longest access, 2-byte bank, zero lead/lag intervals skipped
        set_cfg(2, 0, 2, 0, 31, 3, 0, 1'b1, 1'b0);
        run_access(2, 16'h1000, 1'b0, 16'h0, "R4_acc31_R7", 0, 0);
        run_access(2, 16'h1002, 1'b1, 16'hA55A, "R5_wide_write", 0, 0);

        // R8 page read on a 2-byte bank
        set_cfg(3, 2, 1, 1, 1, 1, 1, 1'b1, 1'b1);
        run_access(3, 16'h2000, 1'b0, 16'h0, "R8_page_wide", 0, 0);
        // R5 write ignores page mode
        run_access(3, 16'h2010, 1'b1, 16'h1234, "R5_page_ignored", 0, 0);

        // R8 page count zero gives one-cycle beats, 1-byte steps
        set_cfg(0, 0, 0, 0, 0, 0, 0, 1'b0, 1'b1);
        run_access(0, 16'h00FE, 1'b0, 16'h0, "R8_page_narrow", 0, 0);

        // R10 reprogramming during an access only affects later accesses
        run_access(1, 16'h0300, 1'b0, 16'h0, "R10_mid_cfg", 1, 6);
        run_access(1, 16'h0304, 1'b0, 16'h0, "R10_after_cfg", 0, 0);

        // R9 back to back requests on different banks
        run_access(2, 16'h0500, 1'b0, 16'h0, "R9_b2b_a", 0, 0);
        run_access(3, 16'h0600, 1'b1, 16'h7777, "R9_b2b_b", 0, 0);

        finish_run();
    end

endmodule